// File: doc/BRIEF.md
# Clock Recovery Lock Detector

This block decides whether a line receiver's clock recovery is tracking the incoming line or still training. It compares a recovered line clock against a local reference clock at the nominal line rate. Recovered-clock edges are counted over a fixed window of reference cycles. A window whose count falls inside a narrow tolerance band around the window length is in range. Two such windows in a row move the block into the locked state. A single window out of range sends it back to training. Losing the line signal sends it back to training at once.

The block drives a loss-of-lock flag and a clock-source select for a downstream glitch-free clock switch. While training, the select asks for the reference clock, so receive timing stays defined with no line present. While locked, it asks for the recovered clock. The recovered-clock count crosses into the reference domain as Gray code through a two-flop synchronizer. The signal-present input is synchronous to the reference clock. The reset is synchronous and active high, and the block also carries it into the recovered-clock domain.

Top module: `lockdet_top`

## Requirements
- R1: During reset and on the first cycle after it, `lol` is 1 and `clk_sel` is 0.
- R2: A measurement window lasts `WIN_LEN` (8192) reference cycles. A window is in range when its recovered-clock edge count lies between `WIN_LEN - TOL` and `WIN_LEN + TOL` inclusive, with `TOL` = 40 (about ±0.49%). A frequency offset of +0.3% or -0.45% is in range. Offsets of +0.7% and -1% are out of range.
- R3: From training, `lol` falls only at the end of the second in-range window in a row. After a single in-range window, `lol` is still 1.
- R4: While locked, a single out-of-range window sets `lol` to 1 at the end of that window.
- R5: When `sig_present` is 0 at a rising `ref_clk` edge, `lol` is 1 and `clk_sel` is 0 after that edge, whatever the window position. The run of good windows is cleared, so after the signal returns, two more in-range windows are needed before lock.
- R6: `clk_sel` is always the inverse of `lol`. A value of 1 selects the recovered clock and 0 selects the reference clock.
- R7: `lol` and `clk_sel` change only at a window end. The one exception is the forced change on signal loss in R5.
- R8: An out-of-range window during training clears the run of good windows. The pattern good, bad, good therefore does not lock.
- R9: The first window after reset only sets the count baseline and counts as neither good nor bad. The earliest lock is at the end of the third window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Local reference clock at the nominal line rate |
| rec_clk | input | 1 | Recovered line clock under test |
| rst | input | 1 | Synchronous active-high reset (reference domain, also carried into the recovered domain) |
| sig_present | input | 1 | Line signal detected, synchronous to `ref_clk` |
| lol | output | 1 | Loss of lock: 1 while training |
| clk_sel | output | 1 | Clock switch select: 1 = recovered clock, 0 = reference clock |

## Verification
The recovered clock is driven at the nominal rate, at +0.3% and -0.45% (inside the band), and at +0.7% and -1% (outside it). Each change of rate falls just after a window boundary, so every window measures a single rate. These rates show whether the comparison uses the right tolerance on both sides of nominal, not just a coarse rate check. Rate patterns of good-good, good-bad-good and a single bad window while locked separate true two-window hysteresis from a single-window decision or a streak that is never cleared. A mid-window drop of signal-present shows the forced fallback that ignores window timing. The relock that follows shows that the run of good windows was cleared.

// File: rtl/lockdet_pkg.sv
`timescale 1ns/1ps
package lockdet_pkg;

    // Detector state: training forwards the reference clock, lock forwards the recovered one
    typedef enum logic {
        ST_TRAIN = 1'b0,
        ST_LOCK  = 1'b1
    } lock_state_e;

    // Outcome of one measurement window, valid for a single cycle when done is set
    typedef struct packed {
        logic done;
        logic ok;
    } win_result_t;

    // True when an edge count lies within nominal +/- tol (all inclusive)
    function automatic logic count_in_band(
        input logic [31:0] count,
        input logic [31:0] nominal,
        input logic [31:0] tol
    );
        return ((count + tol) >= nominal) && (count <= (nominal + tol));
    endfunction

endpackage

// File: rtl/rec_edge_counter.sv
`timescale 1ns/1ps
// Free-running recovered-clock edge counter, published in Gray code
module rec_edge_counter #(
    parameter int unsigned CW = 15
) (
    input  logic          rec_clk,
    input  logic          rst,
    output logic [CW-1:0] gray_q
);
    logic          rst_meta;
    logic          rst_rec;
    logic [CW-1:0] bin_q;
    logic [CW-1:0] bin_nx;

    // carry the reference-domain reset into the recovered domain
    always_ff @(posedge rec_clk) begin
        rst_meta <= rst;
        rst_rec  <= rst_meta;
    end

    assign bin_nx = bin_q + CW'(1);

    always_ff @(posedge rec_clk) begin
        if (rst_rec) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else begin
            bin_q  <= bin_nx;
            gray_q <= bin_nx ^ (bin_nx >> 1);
        end
    end
endmodule

// File: rtl/gray_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer for a Gray count followed by conversion back to binary
module gray_sync #(
    parameter int unsigned CW = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] gray_in,
    output logic [CW-1:0] bin_out
);
    logic [CW-1:0] stage1;
    logic [CW-1:0] stage2;
    logic [CW-1:0] bin_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= gray_in;
            stage2 <= stage1;
        end
    end

    always_comb begin
        bin_c[CW-1] = stage2[CW-1];
        for (int i = int'(CW) - 2; i >= 0; i--) begin
            bin_c[i] = bin_c[i+1] ^ stage2[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) bin_out <= '0;
        else     bin_out <= bin_c;
    end
endmodule

// File: rtl/window_meter.sv
`timescale 1ns/1ps
// Times fixed windows of reference cycles and judges the recovered edge count in each
module window_meter
    import lockdet_pkg::*;
#(
    parameter int unsigned WIN_LEN = 8192,
    parameter int unsigned TOL     = 40,
    parameter int unsigned CW      = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] bin_cnt,
    output win_result_t   res
);
    localparam int unsigned WW = $clog2(WIN_LEN);

    logic [WW-1:0] wcnt;
    logic          at_end;
    logic [CW-1:0] prev_cnt;
    logic [CW-1:0] delta;
    logic          primed;
    logic          band_ok;

    assign at_end  = (wcnt == WW'(WIN_LEN - 1));
    assign delta   = bin_cnt - prev_cnt;
    assign band_ok = count_in_band(32'(delta), 32'(WIN_LEN), 32'(TOL));

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt <= '0;
        end else if (at_end) begin
            wcnt <= '0;
        end else begin
            wcnt <= wcnt + WW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_cnt <= '0;
            primed   <= 1'b0;
            res      <= '0;
        end else begin
            res.done <= at_end;
            res.ok   <= at_end && primed && band_ok;
            if (at_end) begin
                prev_cnt <= bin_cnt;
                primed   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/lock_fsm.sv
`timescale 1ns/1ps
// Two-state lock decision with entry hysteresis and a forced fallback on signal loss
module lock_fsm
    import lockdet_pkg::*;
#(
    parameter int unsigned LOCK_WINS = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sig_present,
    input  win_result_t res,
    output logic        lol,
    output logic        clk_sel
);
    localparam int unsigned SW = $clog2(LOCK_WINS + 1);

    lock_state_e   state;
    logic [SW-1:0] streak;

    always_ff @(posedge clk) begin
        if (rst || !sig_present) begin
            state   <= ST_TRAIN;
            streak  <= '0;
            clk_sel <= 1'b0;
        end else if (res.done) begin
            unique case (state)
                ST_TRAIN: begin
                    if (!res.ok) begin
                        streak <= '0;
                    end else if (streak == SW'(LOCK_WINS - 1)) begin
                        state   <= ST_LOCK;
                        streak  <= '0;
                        clk_sel <= 1'b1;
                    end else begin
                        streak <= streak + SW'(1);
                    end
                end
                ST_LOCK: begin
                    if (!res.ok) begin
                        state   <= ST_TRAIN;
                        clk_sel <= 1'b0;
                    end
                end
                default: begin
                    state   <= ST_TRAIN;
                    clk_sel <= 1'b0;
                end
            endcase
        end
    end

    assign lol = (state == ST_TRAIN);
endmodule

// File: rtl/lockdet_top.sv
`timescale 1ns/1ps
module lockdet_top
    import lockdet_pkg::*;
#(
    parameter int unsigned WIN_LEN   = 8192,
    parameter int unsigned TOL       = 40,
    parameter int unsigned LOCK_WINS = 2
) (
    input  logic ref_clk,
    input  logic rec_clk,
    input  logic rst,
    input  logic sig_present,
    output logic lol,
    output logic clk_sel
);
    // two spare bits so a window count well above nominal never wraps
    localparam int unsigned CW = $clog2(WIN_LEN) + 2;

    logic [CW-1:0] rec_gray;
    logic [CW-1:0] rec_bin;
    win_result_t   res;
    logic          win_end;
    logic          win_ok;

    rec_edge_counter #(.CW(CW)) u_cnt (
        .rec_clk (rec_clk),
        .rst     (rst),
        .gray_q  (rec_gray)
    );

    gray_sync #(.CW(CW)) u_sync (
        .clk     (ref_clk),
        .rst     (rst),
        .gray_in (rec_gray),
        .bin_out (rec_bin)
    );

    window_meter #(.WIN_LEN(WIN_LEN), .TOL(TOL), .CW(CW)) u_meter (
        .clk     (ref_clk),
        .rst     (rst),
        .bin_cnt (rec_bin),
        .res     (res)
    );

    lock_fsm #(.LOCK_WINS(LOCK_WINS)) u_fsm (
        .clk         (ref_clk),
        .rst         (rst),
        .sig_present (sig_present),
        .res         (res),
        .lol         (lol),
        .clk_sel     (clk_sel)
    );

    assign win_end = res.done;
    assign win_ok  = res.ok;
endmodule

// File: rtl/lockdet_chk.sv
`timescale 1ns/1ps
module lockdet_chk (
    input logic clk,
    input logic rst,
    input logic sig_present,
    input logic lol,
    input logic clk_sel,
    input logic win_end,
    input logic win_ok
);
    // R1
    reset_state_chk: assert property (@(posedge clk) $past(rst) |-> (lol && !clk_sel));

    // R6
    sel_inverse_chk: assert property (@(posedge clk) disable iff (rst) clk_sel == !lol);

    // R5
    los_train_chk: assert property (@(posedge clk) disable iff (rst)
        !sig_present |=> (lol && !clk_sel));

    // R7
    lock_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(lol) |-> $past(win_end && win_ok && sig_present));

    // R7
    unlock_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lol) |-> $past(!sig_present || (win_end && !win_ok)));

    // R4
    bad_window_chk: assert property (@(posedge clk) disable iff (rst)
        (!lol && win_end && !win_ok) |=> lol);
endmodule

bind lockdet_top lockdet_chk u_chk (
    .clk         (ref_clk),
    .rst         (rst),
    .sig_present (sig_present),
    .lol         (lol),
    .clk_sel     (clk_sel),
    .win_end     (win_end),
    .win_ok      (win_ok)
);

// File: tb/sim_lockdet_top.sv
`timescale 1ns/1ps
module sim_lockdet_top;
    localparam int N = 8192;

    typedef struct {
        int    cyc;
        logic  lol;
        string tag;
    } exp_t;

    logic ref_clk = 1'b0;
    logic rec_clk = 1'b0;
    logic rst = 1'b1;
    logic sig_present = 1'b1;
    logic lol;
    logic clk_sel;

    real  rec_half = 4.0;
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   mon_done = 1'b0;
    exp_t exp_q[$];

    lockdet_top u0 (
        .ref_clk     (ref_clk),
        .rec_clk     (rec_clk),
        .rst         (rst),
        .sig_present (sig_present),
        .lol         (lol),
        .clk_sel     (clk_sel)
    );

    always #4 ref_clk = ~ref_clk;           // 125 MHz reference
    always #(rec_half) rec_clk = ~rec_clk;  // recovered clock, rate set by stimulus

    always @(posedge ref_clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    task automatic wait_cyc(input int c);
        while (cyc < c) @(negedge ref_clk);
    endtask

    // driver side of the scoreboard
    task automatic expect_at(input int c, input logic l, input string tag);
        exp_t e;
        e.cyc = c; e.lol = l; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic set_offset(input real frac);
        rec_half = 4.0 / (1.0 + frac);
    endtask

    // expected values
    initial begin
        expect_at(1,           1'b1, "R1 reset state");
        expect_at(2*N + N/2,   1'b1, "R9 R3 one good window after baseline");
        expect_at(3*N + N/2,   1'b0, "R3 locked after two good windows");
        expect_at(4*N + N/2,   1'b1, "R4 R2 -1% window drops lock");
        expect_at(5*N + N/2,   1'b1, "R3 +0.3% one window not enough");
        expect_at(6*N + N/2,   1'b0, "R2 +0.3% in band locks");
        expect_at(6*N + N/2 + 103, 1'b1, "R5 signal loss forces training");
        expect_at(8*N + N/2,   1'b1, "R5 streak cleared by signal loss");
        expect_at(9*N + N/2,   1'b0, "R5 relock after signal returns");
        expect_at(10*N + N/2,  1'b1, "R2 +0.7% out of band");
        expect_at(12*N + N/2,  1'b0, "R2 -0.45% in band");
        expect_at(14*N + N/2,  1'b1, "R8 good after bad not enough");
        expect_at(16*N + N/2,  1'b1, "R8 bad window clears streak");
        expect_at(17*N + N/2,  1'b0, "R8 two good windows relock");
    end

    // stimulus
    initial begin
        repeat (20) @(negedge ref_clk);
        rst = 1'b0;
        wait_cyc(3*N + 4);   set_offset(-0.01);
        wait_cyc(4*N + 4);   set_offset(0.003);
        wait_cyc(6*N + N/2 + 100); sig_present = 1'b0;
        wait_cyc(7*N + 4);   sig_present = 1'b1;
        wait_cyc(9*N + 4);   set_offset(0.007);
        wait_cyc(10*N + 4);  set_offset(-0.0045);
        wait_cyc(12*N + 4);  set_offset(-0.01);
        wait_cyc(13*N + 4);  set_offset(0.0);
        wait_cyc(14*N + 4);  set_offset(-0.01);
        wait_cyc(15*N + 4);  set_offset(0.0);
    end

    // monitor side of the scoreboard; R6 is checked with every item
    initial begin
        exp_t e;
        @(negedge ref_clk);
        wait (rst == 1'b0);
        while (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            wait_cyc(e.cyc);
            n_chk++;
            if (lol !== e.lol) begin
                n_fail++;
                $display("FAIL %s: lol actual %0b expected %0b (cycle %0d)", e.tag, lol, e.lol, cyc);
            end
            n_chk++;
            if (clk_sel !== ~e.lol) begin
                n_fail++;
                $display("FAIL R6 %s: clk_sel actual %0b expected %0b (cycle %0d)", e.tag, clk_sel, ~e.lol, cyc);
            end
        end
        mon_done = 1'b1;
    end

    initial begin
        fork
            wait (mon_done);
            begin
                #(200000 * 8);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule